// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a real address through a small set of block translation entries. Each entry is held as a raw upper/lower register pair. The upper word carries the block's effective page index, a block-length code and two mode-valid flags. The lower word carries the real page number and a two-bit protection code. Separate instances serve instruction fetches and data accesses. The registers are written elsewhere, so the unit only reads them.

Every cycle the unit looks at the effective address, the access kind, the problem-state flag and the relocation enable. One clock later it reports one of four outcomes:

- a block hit, with the translated real address;
- a protection fault;
- a miss, in which case a page-table path elsewhere takes over;
- a bypass when relocation is off, with the address passed through unchanged.

The unit raises no interrupt. It only flags the fault.

Top module: `bat_xlate_unit`

## Requirements
- R1: When `reloc_en` is 0, one cycle later `real_addr` equals the effective address, and `blk_hit` and `prot_fault` are both 0, whatever the entries hold.
- R2: An entry is a candidate only if `upper[0]` is set while `prob_state` is 0, or `upper[1]` is set while `prob_state` is 1. A change of `prob_state` applies to the very next lookup.
- R3: The offset mask is the 11-bit length field `upper[12:2]` placed at bits [27:17], ORed with ones over bits [16:0]. An entry matches when (EA AND NOT offset mask) equals `upper` with bits [16:0] cleared.
- R4: When several candidates match, the lowest-numbered one is used.
- R5: On a hit, `real_addr` = (EA AND offset mask) OR (`lower` with bits [16:0] cleared).
- R6: Protection code `lower[1:0]`=00 denies every access kind.
- R7: Protection codes 01 and 11 deny writes and allow reads and fetches. The access kind encodings are 00 read, 01 write, 10 fetch, and 11 is treated as a read.
- R8: Protection code 10 allows every access kind.
- R9: A denied access gives `prot_fault`=1, `blk_hit`=0 and `real_addr`=0.
- R10: With relocation on and no matching candidate, all three outputs are 0.
- R11: All outputs are registered with one cycle of latency. A synchronous active-high `rst` clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upper_regs | input | NUM_ENTRIES*32 | Upper words of all entries; entry i sits at [32*i +: 32] |
| lower_regs | input | NUM_ENTRIES*32 | Lower words of all entries; entry i sits at [32*i +: 32] |
| prob_state | input | 1 | 1 = problem (user) state, 0 = supervisor state |
| reloc_en | input | 1 | Translation enable |
| eff_addr | input | 32 | Effective address to translate |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| blk_hit | output | 1 | A block entry translated the address |
| real_addr | output | 32 | Translated or passed-through address |
| prot_fault | output | 1 | The matched entry denies this access |

## Verification
A wrong mask, a wrong mode-flag selection or a wrong priority inside the unit shows up as a wrong `real_addr` or `blk_hit`. It appears in the cycle after the offending lookup, because the only state is the output register. A wrong protection decode appears as `prot_fault` set or clear against the access kind in that same cycle. The bench therefore compares every output on every clock against a behavioural model. The stimulus includes overlapping entries, both length extremes, every protection code under every access kind, and a `prob_state` that toggles between consecutive lookups.

// File: rtl/bat_pkg.sv
package bat_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // Access matrix: 00 nothing, 10 everything, 01/11 everything but stores.
  function automatic logic prot_allows(input logic [1:0] code, input acc_e acc);
    logic ok;
    case (code)
      2'b00:   ok = 1'b0;
      2'b10:   ok = 1'b1;
      default: ok = (acc != ACC_STORE);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/bat_entry_decode.sv
module bat_entry_decode #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 17,
  parameter int LEN_W    = 11
) (
  input  logic [ADDR_W-1:0] upper,
  input  logic [ADDR_W-1:0] lower,
  input  logic              prob_state,
  input  logic [ADDR_W-1:0] ea,
  output logic              sel_ok,
  output logic [ADDR_W-1:0] xlated,
  output logic [1:0]        prot_code
);
  localparam int LEN_LSB = 2;
  localparam int LEN_MSB = LEN_LSB + LEN_W - 1;
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W-PAGE_LSB){1'b1}}, {PAGE_LSB{1'b0}}};

  logic [ADDR_W-1:0] off_mask;
  logic              in_mode;

  always_comb begin
    off_mask = '0;
    off_mask[PAGE_LSB +: LEN_W] = upper[LEN_MSB:LEN_LSB];
    off_mask[PAGE_LSB-1:0]      = '1;
  end

  assign in_mode   = prob_state ? upper[1] : upper[0];
  assign sel_ok    = in_mode && ((ea & ~off_mask) == (upper & PAGE_MASK));
  assign xlated    = (ea & off_mask) | (lower & PAGE_MASK);
  assign prot_code = lower[1:0];

endmodule

// File: rtl/bat_priority_sel.sv
module bat_priority_sel #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32
) (
  input  logic [NUM_ENTRIES-1:0]             sel_ok,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] xlated,
  input  logic [NUM_ENTRIES-1:0][1:0]        prot,
  output logic                               any_sel,
  output logic [ADDR_W-1:0]                  win_addr,
  output logic [1:0]                         win_prot
);
  always_comb begin
    any_sel  = 1'b0;
    win_addr = '0;
    win_prot = 2'b00;
    // Walk downward so the lowest-numbered match is written last and wins.
    for (int i = NUM_ENTRIES-1; i >= 0; i--) begin
      if (sel_ok[i]) begin
        any_sel  = 1'b1;
        win_addr = xlated[i];
        win_prot = prot[i];
      end
    end
  end
endmodule

// File: rtl/bat_prot_check.sv
module bat_prot_check
  import bat_pkg::*;
(
  input  logic [1:0] code,
  input  logic [1:0] acc_raw,
  output logic       allowed
);
  assign allowed = prot_allows(code, acc_e'(acc_raw));
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int PAGE_LSB    = 17,
  parameter int LEN_W       = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] upper_regs,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] lower_regs,
  input  logic                          prob_state,
  input  logic                          reloc_en,
  input  logic [ADDR_W-1:0]             eff_addr,
  input  logic [1:0]                    acc_kind,
  output logic                          blk_hit,
  output logic [ADDR_W-1:0]             real_addr,
  output logic                          prot_fault
);
  logic [NUM_ENTRIES-1:0]             sel_ok;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] xlated;
  logic [NUM_ENTRIES-1:0][1:0]        prot;
  logic                               any_sel;
  logic [ADDR_W-1:0]                  win_addr;
  logic [1:0]                         win_prot;
  logic                               allowed;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    bat_entry_decode #(
      .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .LEN_W(LEN_W)
    ) i_dec (
      .upper     (upper_regs[g*ADDR_W +: ADDR_W]),
      .lower     (lower_regs[g*ADDR_W +: ADDR_W]),
      .prob_state(prob_state),
      .ea        (eff_addr),
      .sel_ok    (sel_ok[g]),
      .xlated    (xlated[g]),
      .prot_code (prot[g])
    );
  end

  bat_priority_sel #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) i_sel (
    .sel_ok  (sel_ok),
    .xlated  (xlated),
    .prot    (prot),
    .any_sel (any_sel),
    .win_addr(win_addr),
    .win_prot(win_prot)
  );

  bat_prot_check i_prot (
    .code   (win_prot),
    .acc_raw(acc_kind),
    .allowed(allowed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_hit    <= 1'b0;
      prot_fault <= 1'b0;
      real_addr  <= '0;
    end else if (!reloc_en) begin
      blk_hit    <= 1'b0;
      prot_fault <= 1'b0;
      real_addr  <= eff_addr;
    end else if (any_sel && allowed) begin
      blk_hit    <= 1'b1;
      prot_fault <= 1'b0;
      real_addr  <= win_addr;
    end else begin
      blk_hit    <= 1'b0;
      prot_fault <= any_sel;
      real_addr  <= '0;
    end
  end

  // Mode-valid flags read straight from the ports, apart from the decoders.
  logic any_mode_valid;
  always_comb begin
    any_mode_valid = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      any_mode_valid |= upper_regs[i*ADDR_W + (prob_state ? 1 : 0)];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!blk_hit && !prot_fault && real_addr == '0)); // R11

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    !reloc_en |=> (real_addr == $past(eff_addr) && !blk_hit && !prot_fault)); // R1

  AST_NO_CANDIDATE: assert property (@(posedge clk) disable iff (rst)
    (reloc_en && !any_mode_valid) |=> (!blk_hit && !prot_fault)); // R10

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    blk_hit |-> (real_addr[PAGE_LSB-1:0] == $past(eff_addr[PAGE_LSB-1:0]))); // R5

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(blk_hit && prot_fault)); // R9

endmodule

// File: tb/test_bat_xlate_unit.sv
`timescale 1ns/1ps
module test_bat_xlate_unit;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] up [N];
  logic [31:0] lo [N];
  logic        prob_state = 1'b0;
  logic        reloc_en = 1'b0;
  logic [31:0] eff_addr = '0;
  logic [1:0]  acc_kind = 2'b00;
  logic        blk_hit, prot_fault;
  logic [31:0] real_addr;
  logic [N*32-1:0] up_flat, lo_flat;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      up_flat[i*32 +: 32] = up[i];
      lo_flat[i*32 +: 32] = lo[i];
    end

  bat_xlate_unit i_bat_xlate_unit (
    .clk(clk), .rst(rst), .upper_regs(up_flat), .lower_regs(lo_flat),
    .prob_state(prob_state), .reloc_en(reloc_en), .eff_addr(eff_addr),
    .acc_kind(acc_kind), .blk_hit(blk_hit), .real_addr(real_addr),
    .prot_fault(prot_fault)
  );

  logic        e_hit, e_fault;
  logic [31:0] e_ra;

  // Behavioural reference following the requirements.
  task automatic model();
    int  pick = -1;
    logic [31:0] om;
    logic ok;
    e_hit = 0; e_fault = 0; e_ra = 0;
    if (!reloc_en) begin e_ra = eff_addr; return; end
    for (int i = 0; i < N; i++) begin
      logic [31:0] m;
      if (pick >= 0) continue;
      if (!(prob_state ? up[i][1] : up[i][0])) continue;
      m = (((up[i] >> 2) & 32'h7ff) << 17) | 32'h1ffff;
      if ((eff_addr & ~m) == (up[i] & 32'hfffe0000)) begin pick = i; om = m; end
    end
    if (pick < 0) return;
    case (lo[pick][1:0])
      2'b00: ok = 0;
      2'b10: ok = 1;
      default: ok = (acc_kind != 2'b01);
    endcase
    if (ok) begin
      e_hit = 1;
      e_ra = (eff_addr & om) | (lo[pick] & 32'hfffe0000);
    end else e_fault = 1;
  endtask

  task automatic compare(string tag);
    compared++;
    if (blk_hit !== e_hit || prot_fault !== e_fault || real_addr !== e_ra) begin
      mismatched++;
      $display("FAIL %s: actual hit=%0b fault=%0b ra=%h expected hit=%0b fault=%0b ra=%h",
               tag, blk_hit, prot_fault, real_addr, e_hit, e_fault, e_ra);
    end
  endtask

  // Called at a falling edge: drive, predict, compare at the next falling edge.
  task automatic step(string tag, logic [31:0] ea, logic [1:0] acc, logic ps, logic re);
    eff_addr = ea; acc_kind = acc; prob_state = ps; reloc_en = re;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin up[i] = '0; lo[i] = '0; end
    repeat (3) @(negedge clk);
    e_hit = 0; e_fault = 0; e_ra = 0;
    compare("R11 reset");
    rst = 1'b0;

    // Entry 0: supervisor, 128 KB at 1000_0000 -> 8000_0000, full access.
    up[0] = 32'h1000_0001; lo[0] = 32'h8000_0002;
    // Entry 1: problem, 256 MB at 2000_0000 -> 3000_0000, no stores.
    up[1] = 32'h2000_0000 | (32'h7ff << 2) | 32'h2; lo[1] = 32'h3000_0001;
    // Entry 2: both modes, 128 KB at 1000_0000 (overlaps 0), denies all.
    up[2] = 32'h1000_0003; lo[2] = 32'h5000_0000;
    // Entry 3: both modes, 1 MB at 4000_0000, code 11.
    up[3] = 32'h4000_0000 | (32'h7 << 2) | 32'h3; lo[3] = 32'h6000_0003;

    step("R1 bypass", 32'h1000_1234, 2'b01, 0, 0);
    step("R1 bypass", 32'hdead_beef, 2'b10, 1, 0);
    step("R5 hit entry0", 32'h1000_1234, 2'b00, 0, 1);
    step("R8 store allowed", 32'h1001_ffff, 2'b01, 0, 1);
    step("R8 fetch allowed", 32'h1000_0000, 2'b10, 0, 1);
    step("R4 overlap problem uses entry2", 32'h1000_1234, 2'b00, 1, 1);
    step("R6 deny fetch", 32'h1000_0004, 2'b10, 1, 1);
    step("R6 deny store", 32'h1000_0004, 2'b01, 1, 1);
    step("R2 mode back to supervisor", 32'h1000_0004, 2'b01, 0, 1);
    step("R3 long block", 32'h2abc_def0, 2'b00, 1, 1);
    step("R2 problem-only unseen in supervisor", 32'h2abc_def0, 2'b00, 0, 1);
    step("R7 store denied", 32'h2abc_def0, 2'b01, 1, 1);
    step("R7 fetch allowed", 32'h2000_0010, 2'b10, 1, 1);
    step("R7 code11 reserved kind as read", 32'h400f_fff0, 2'b11, 0, 1);
    step("R7 code11 store denied", 32'h4001_0000, 2'b01, 0, 1);
    step("R9 fault outputs", 32'h4001_0000, 2'b01, 1, 1);
    step("R3 just past 1MB", 32'h4010_0000, 2'b00, 0, 1);
    step("R3 just past 128KB", 32'h1002_0000, 2'b00, 0, 1);
    step("R10 miss", 32'h7000_0000, 2'b00, 0, 1);
    step("R11 latency after miss", 32'h1000_0100, 2'b00, 0, 1);

    // Stress with random entries and addresses near their blocks.
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ea;
      if (k % 25 == 0)
        for (int i = 0; i < N; i++) begin
          up[i] = $urandom();
          up[i][16:13] = 4'h0;
          if ($urandom_range(0, 1)) up[i][31:17] &= ~(up[i][12:2] << 0);
          lo[i] = $urandom();
        end
      ea = $urandom();
      if ($urandom_range(0, 2) != 0) begin
        int j = $urandom_range(0, N-1);
        ea = (up[j] & 32'hfffe0000) | (ea & ((((up[j] >> 2) & 32'h7ff) << 17) | 32'h1ffff));
      end
      step("R4 random mix", ea, 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule